// File: doc/BRIEF.md
# Receive Descriptor Buffer Sequencer

This block turns one receive DMA descriptor into a stream of write addresses for an incoming frame. The descriptor words arrive already fetched. They are the control word, which carries both buffer sizes and the chain flag, the first buffer pointer, the second pointer, and the address of the descriptor itself. The block takes them on a one-cycle `go` strobe. From that point it tracks where each 32-bit word of frame data lands. It skips a buffer whose size is zero, and it stops early when the frame ends. When it is done it reports where the next descriptor lives.

A pointer to the start of a frame may be misaligned. In that case the block issues the word address with the two low bits cleared and reports those bits as a byte-lane shift. The data path in front of memory applies that shift. Pointers to continuation buffers are always treated as word-aligned. A descriptor with a size that is not a multiple of four is rejected with a configuration error pulse. A chained descriptor whose next pointer is misaligned is rejected with a pointer error pulse. In both cases no buffer is walked.

The controller has four states. IDLE waits for `go`. FILL1 walks buffer 1. FILL2 walks buffer 2. LINK presents the next-descriptor address for one cycle. The transitions are as follows:

- IDLE goes to FILL1, FILL2 or LINK when an accepted `go` arrives.
- FILL1 goes to FILL2 or LINK when a write finishes buffer 1.
- FILL2 goes to LINK when a write finishes buffer 2.
- LINK always returns to IDLE.

IDLE stays put on a rejected `go`.

Top module: `rx_buf_seq`

## Requirements
- R1: After a synchronous active-high reset the block is idle: `busy`=0, `buf_id`=0, and `wr_addr`, `bytes_left`, `lane_shift`, `buf_done`, `nxt_valid`, `cfg_err` and `ptr_err` are all 0.
- R2: The control word holds the buffer 1 byte size in bits 12:0 and the buffer 2 byte size in bits 28:16. When buffer 1 size is nonzero, the cycle after an accepted `go` shows `buf_id`=1, `wr_addr` = buffer 1 pointer with bits 1:0 cleared, and `bytes_left` = buffer 1 size.
- R3: A zero buffer 1 size skips buffer 1. The block enters buffer 2 (`buf_id`=2) if buffer 2 is usable, otherwise it goes straight to the link state (`buf_id`=3). Buffer 2 is usable when chaining is off and its size is nonzero.
- R4: Control word bit 14 set selects chaining. Buffer 2 is then never entered, and `nxt_addr` equals the second pointer.
- R5: With bit 14 clear, the second pointer is the buffer 2 address with no restriction on its value, and `nxt_addr` equals the descriptor address plus 32.
- R6: With chaining on, a second pointer with bits 1:0 nonzero makes `ptr_err` pulse for one cycle and the block stays idle.
- R7: A buffer 1 size that is not a multiple of 4, or a buffer 2 size that is not a multiple of 4 while chaining is off, makes `cfg_err` pulse for one cycle and the block stays idle.
- R8: The first buffer entered for a `go` with `go_sof`=1 reports `lane_shift` = its pointer bits 1:0. Every other buffer reports `lane_shift`=0 with its pointer bits 1:0 ignored.
- R9: Each `wr_valid` cycle inside a buffer advances `wr_addr` by 4 and lowers `bytes_left` by `wr_bytes`, floored at 0.
- R10: A write that empties the buffer count, or that carries `frame_end`, makes `buf_done` pulse in the following cycle. The block then moves to buffer 2 if that buffer is usable and the frame has not ended; otherwise it moves to the link state.
- R11: The link state lasts exactly one cycle, with `nxt_valid`=1. The block is idle in the next cycle. A `go` that arrives while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start strobe; descriptor inputs valid |
| go_sof | input | 1 | Descriptor receives the start of a frame |
| desc_addr | input | 32 | Address of the current descriptor |
| ctrl_word | input | 32 | Sizes (12:0, 28:16) and chain flag (14) |
| buf1_ptr | input | 32 | Buffer 1 pointer |
| buf2_ptr | input | 32 | Buffer 2 pointer or next-descriptor pointer |
| wr_valid | input | 1 | One 32-bit data word is written this cycle |
| wr_bytes | input | 3 | Valid bytes in that word (1 to 4) |
| frame_end | input | 1 | This word is the last of the frame |
| busy | output | 1 | Not idle |
| buf_id | output | 2 | 0 idle, 1 buffer 1, 2 buffer 2, 3 link |
| wr_addr | output | 32 | Word-aligned write address |
| lane_shift | output | 2 | Byte-lane shift of the data |
| bytes_left | output | 13 | Remaining bytes in the current buffer |
| buf_done | output | 1 | Buffer finished (one-cycle pulse) |
| nxt_valid | output | 1 | `nxt_addr` valid (link state) |
| nxt_addr | output | 32 | Next descriptor address |
| cfg_err | output | 1 | Size error, descriptor rejected |
| ptr_err | output | 1 | Misaligned chain pointer, descriptor rejected |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 13-bit size fields and a 32-byte ring stride. It drives buffer sizes of 0 to 12 bytes, so every walk stays within a few words. This small range lets a single sweep cover every combination of the following:

- zero and nonzero sizes for both buffers;
- chained and ring mode;
- all four low pointer bits;
- start and continuation descriptors.

Directed cases add partial-word writes, a floored count, an early frame end, both rejection causes, and a strobe while busy.

// File: rtl/rx_seq_pkg.sv
package rx_seq_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FILL1 = 2'd1,
        S_FILL2 = 2'd2,
        S_LINK  = 2'd3
    } seq_state_e;

    localparam int SZ1_LSB   = 0;
    localparam int SZ2_LSB   = 16;
    localparam int CHAIN_BIT = 14;

endpackage

// File: rtl/rx_desc_decode.sv
module rx_desc_decode
    import rx_seq_pkg::*;
#(
    parameter int AW     = 32,
    parameter int SZW    = 13,
    parameter int STRIDE = 32
) (
    input  logic [31:0]    ctrl,
    input  logic [AW-1:0]  ptr_b,
    input  logic [AW-1:0]  self_addr,
    output logic [SZW-1:0] size1,
    output logic [SZW-1:0] size2,
    output logic           use1,
    output logic           use2,
    output logic           cfg_bad,
    output logic           ptr_bad,
    output logic [AW-1:0]  link_ptr
);
    localparam logic [AW-1:0] STRIDE_V = AW'(STRIDE);

    logic chained;
    logic unused_ctrl;

    assign unused_ctrl = ^{ctrl[31:SZ2_LSB+SZW], ctrl[15], ctrl[SZ1_LSB+SZW]};
    assign size1    = ctrl[SZ1_LSB +: SZW];
    assign size2    = ctrl[SZ2_LSB +: SZW];
    assign chained  = ctrl[CHAIN_BIT];
    assign use1     = (size1 != '0);
    assign use2     = !chained && (size2 != '0);
    assign cfg_bad  = (size1[1:0] != 2'b00) || (!chained && (size2[1:0] != 2'b00));
    assign ptr_bad  = chained && (ptr_b[1:0] != 2'b00);
    assign link_ptr = chained ? ptr_b : (self_addr + STRIDE_V);

endmodule

// File: rtl/rx_buf_track.sv
module rx_buf_track #(
    parameter int AW  = 32,
    parameter int SZW = 13
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [AW-1:0]  load_ptr,
    input  logic [SZW-1:0] load_size,
    input  logic           load_sof,
    input  logic           step,
    input  logic [2:0]     step_bytes,
    output logic [AW-1:0]  addr,
    output logic [SZW-1:0] left,
    output logic [1:0]     shift,
    output logic           drains
);
    localparam logic [AW-1:0] WORD_STEP = AW'(4);

    logic [SZW-1:0] step_w;

    assign step_w = SZW'(step_bytes);
    assign drains = (step_w >= left);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr  <= '0;
            left  <= '0;
            shift <= 2'b00;
        end else if (load) begin
            addr  <= {load_ptr[AW-1:2], 2'b00};
            left  <= load_size;
            shift <= load_sof ? load_ptr[1:0] : 2'b00;
        end else if (step) begin
            addr <= addr + WORD_STEP;
            left <= drains ? '0 : (left - step_w);
        end
    end

endmodule

// File: rtl/rx_buf_seq.sv
module rx_buf_seq
    import rx_seq_pkg::*;
#(
    parameter int AW     = 32,
    parameter int SZW    = 13,
    parameter int STRIDE = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           go,
    input  logic           go_sof,
    input  logic [AW-1:0]  desc_addr,
    input  logic [31:0]    ctrl_word,
    input  logic [AW-1:0]  buf1_ptr,
    input  logic [AW-1:0]  buf2_ptr,
    input  logic           wr_valid,
    input  logic [2:0]     wr_bytes,
    input  logic           frame_end,
    output logic           busy,
    output logic [1:0]     buf_id,
    output logic [AW-1:0]  wr_addr,
    output logic [1:0]     lane_shift,
    output logic [SZW-1:0] bytes_left,
    output logic           buf_done,
    output logic           nxt_valid,
    output logic [AW-1:0]  nxt_addr,
    output logic           cfg_err,
    output logic           ptr_err
);
    seq_state_e     state, state_nx;
    logic [SZW-1:0] size1, size2, size2_q;
    logic           use1, use2, use2_q;
    logic           cfg_bad, ptr_bad, accept;
    logic [AW-1:0]  link_ptr, p2_q;
    logic           in_buf, drains, fin;
    logic           ld, ld_sof;
    logic [AW-1:0]  ld_ptr;
    logic [SZW-1:0] ld_size;

    rx_desc_decode #(.AW(AW), .SZW(SZW), .STRIDE(STRIDE)) u_dec (
        .ctrl     (ctrl_word),
        .ptr_b    (buf2_ptr),
        .self_addr(desc_addr),
        .size1    (size1),
        .size2    (size2),
        .use1     (use1),
        .use2     (use2),
        .cfg_bad  (cfg_bad),
        .ptr_bad  (ptr_bad),
        .link_ptr (link_ptr)
    );

    assign accept = go && !cfg_bad && !ptr_bad;
    assign in_buf = (state == S_FILL1) || (state == S_FILL2);
    assign fin    = in_buf && wr_valid && (frame_end || drains);

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (accept) begin
                    if (use1)      state_nx = S_FILL1;
                    else if (use2) state_nx = S_FILL2;
                    else           state_nx = S_LINK;
                end
            end
            S_FILL1: begin
                if (fin) state_nx = (frame_end || !use2_q) ? S_LINK : S_FILL2;
            end
            S_FILL2: begin
                if (fin) state_nx = S_LINK;
            end
            S_LINK:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    assign ld      = ((state == S_IDLE) && accept) ||
                     ((state == S_FILL1) && fin && !frame_end && use2_q);
    assign ld_ptr  = (state == S_IDLE) ? (use1 ? buf1_ptr : buf2_ptr) : p2_q;
    assign ld_size = (state == S_IDLE) ? (use1 ? size1 : size2) : size2_q;
    assign ld_sof  = (state == S_IDLE) && go_sof;

    rx_buf_track #(.AW(AW), .SZW(SZW)) u_trk (
        .clk       (clk),
        .rst       (rst),
        .load      (ld),
        .load_ptr  (ld_ptr),
        .load_size (ld_size),
        .load_sof  (ld_sof),
        .step      (in_buf && wr_valid && !ld),
        .step_bytes(wr_bytes),
        .addr      (wr_addr),
        .left      (bytes_left),
        .shift     (lane_shift),
        .drains    (drains)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= state_nx;
    end

    // Registered outputs and descriptor fields held for the walk
    always_ff @(posedge clk) begin
        if (rst) begin
            buf_done <= 1'b0;
            cfg_err  <= 1'b0;
            ptr_err  <= 1'b0;
            use2_q   <= 1'b0;
            size2_q  <= '0;
            p2_q     <= '0;
            nxt_addr <= '0;
        end else begin
            buf_done <= fin;
            cfg_err  <= (state == S_IDLE) && go && cfg_bad;
            ptr_err  <= (state == S_IDLE) && go && ptr_bad;
            if ((state == S_IDLE) && accept) begin
                use2_q   <= use2;
                size2_q  <= size2;
                p2_q     <= buf2_ptr;
                nxt_addr <= link_ptr;
            end
        end
    end

    assign busy      = (state != S_IDLE);
    assign buf_id    = state;
    assign nxt_valid = (state == S_LINK);

endmodule

// File: rtl/rx_buf_seq_chk.sv
module rx_buf_seq_chk #(
    parameter int AW  = 32,
    parameter int SZW = 13
) (
    input logic           clk,
    input logic           rst,
    input logic           wr_valid,
    input logic           busy,
    input logic [1:0]     buf_id,
    input logic [AW-1:0]  wr_addr,
    input logic [1:0]     lane_shift,
    input logic [SZW-1:0] bytes_left,
    input logic           buf_done,
    input logic           nxt_valid,
    input logic           cfg_err,
    input logic           ptr_err
);
    a_r11_link_one_cycle: assert property (@(posedge clk) disable iff (rst)
        nxt_valid |=> (!nxt_valid && !busy));

    a_r2_addr_word_aligned: assert property (@(posedge clk) disable iff (rst)
        busy |-> (wr_addr[1:0] == 2'b00));

    a_r7_cfg_reject_idle: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !busy);

    a_r6_ptr_reject_idle: assert property (@(posedge clk) disable iff (rst)
        ptr_err |-> !busy);

    a_r10_done_follows_write: assert property (@(posedge clk) disable iff (rst)
        buf_done |-> ($past(wr_valid) && $past(busy)));

    a_r8_second_buffer_unshifted: assert property (@(posedge clk) disable iff (rst)
        ((buf_id == 2'd2) && ($past(buf_id) == 2'd1)) |-> (lane_shift == 2'b00));

    a_r9_count_never_rises: assert property (@(posedge clk) disable iff (rst)
        (((buf_id == 2'd1) || (buf_id == 2'd2)) && (buf_id == $past(buf_id)))
            |-> (bytes_left <= $past(bytes_left)));

endmodule

bind rx_buf_seq rx_buf_seq_chk #(.AW(AW), .SZW(SZW)) u_chk (.*);

// File: tb/test_rx_buf_seq.sv
module test_rx_buf_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        go = 1'b0, go_sof = 1'b0;
    logic [31:0] desc_addr = '0, ctrl_word = '0, buf1_ptr = '0, buf2_ptr = '0;
    logic        wr_valid = 1'b0;
    logic [2:0]  wr_bytes = 3'd0;
    logic        frame_end = 1'b0;
    logic        busy, buf_done, nxt_valid, cfg_err, ptr_err;
    logic [1:0]  buf_id, lane_shift;
    logic [31:0] wr_addr, nxt_addr;
    logic [12:0] bytes_left;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_buf_seq i_rx_buf_seq (
        .clk(clk), .rst(rst), .go(go), .go_sof(go_sof), .desc_addr(desc_addr),
        .ctrl_word(ctrl_word), .buf1_ptr(buf1_ptr), .buf2_ptr(buf2_ptr),
        .wr_valid(wr_valid), .wr_bytes(wr_bytes), .frame_end(frame_end),
        .busy(busy), .buf_id(buf_id), .wr_addr(wr_addr), .lane_shift(lane_shift),
        .bytes_left(bytes_left), .buf_done(buf_done), .nxt_valid(nxt_valid),
        .nxt_addr(nxt_addr), .cfg_err(cfg_err), .ptr_err(ptr_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_sim();
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [31:0] mk_ctrl(int s1, int s2, bit chain);
        return (32'(s2) << 16) | (32'(chain) << 14) | 32'(s1);
    endfunction

    task automatic start(bit sof, logic [31:0] d, logic [31:0] c, logic [31:0] a1, logic [31:0] a2);
        go = 1'b1; go_sof = sof; desc_addr = d; ctrl_word = c; buf1_ptr = a1; buf2_ptr = a2;
        @(negedge clk);
        go = 1'b0; go_sof = 1'b0;
    endtask

    task automatic wr(int nb, bit fe);
        wr_valid = 1'b1; wr_bytes = 3'(nb); frame_end = fe;
        @(negedge clk);
        wr_valid = 1'b0; frame_end = 1'b0;
    endtask

    // Walk one buffer with full words; returns after the finishing write
    task automatic walk(string tag, int id, logic [31:0] ptr, int sz, logic [1:0] sh);
        check({tag, " buf_id"}, 32'(buf_id), 32'(id));
        check({tag, " addr"}, wr_addr, {ptr[31:2], 2'b00});
        check({tag, " left"}, 32'(bytes_left), 32'(sz));
        check({tag, " R8 shift"}, 32'(lane_shift), 32'(sh));
        for (int k = 0; k < sz / 4; k++) begin
            wr(4, 0);
            if (k < sz / 4 - 1) begin
                check({tag, " R9 addr step"}, wr_addr, {ptr[31:2], 2'b00} + 32'(4 * (k + 1)));
                check({tag, " R9 left step"}, 32'(bytes_left), 32'(sz - 4 * (k + 1)));
            end else begin
                check({tag, " R10 done"}, 32'(buf_done), 32'd1);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_sim();
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 busy", 32'(busy), 0);
        check("R1 buf_id", 32'(buf_id), 0);
        check("R1 wr_addr", wr_addr, 0);
        check("R1 left", 32'(bytes_left), 0);
        check("R1 flags", {27'd0, lane_shift, buf_done, nxt_valid, cfg_err | ptr_err}, 0);

        // Sweep: sizes, mode, pointer low bits, start of frame
        for (int s1 = 0; s1 <= 12; s1 += 4)
        for (int s2 = 0; s2 <= 8; s2 += 4)
        for (int ch = 0; ch < 2; ch++)
        for (int lo = 0; lo < 4; lo++)
        for (int sof = 0; sof < 2; sof++) begin
            logic [31:0] d, a1, a2;
            bit u1, u2;
            d  = 32'h0000_4000 + 32'(s1 * 64 + s2 * 8);
            a1 = 32'h1000_0000 + 32'(lo);
            a2 = ch ? 32'h3000_0040 : 32'h2000_0100 + 32'((lo + 1) % 4);
            u1 = (s1 != 0);
            u2 = (ch == 0) && (s2 != 0);
            start(sof[0], d, mk_ctrl(s1, s2, ch[0]), a1, a2);
            check("R7 R6 no error", 32'({cfg_err, ptr_err}), 0);
            if (u1) walk("R2 fill1", 1, a1, s1, sof ? a1[1:0] : 2'b00);
            else if (u2) check("R3 skip to buffer 2", 32'(buf_id), 2);
            else check("R3 skip to link", 32'(buf_id), 3);
            if (u2) walk(ch ? "R4 fill2" : "R5 fill2", 2, a2, s2, (!u1 && sof) ? a2[1:0] : 2'b00);
            check("R11 link", 32'({nxt_valid, buf_id}), 32'h7);
            if (ch) check("R4 chain next", nxt_addr, a2);
            else    check("R5 ring next", nxt_addr, d + 32'd32);
            @(negedge clk);
            check("R11 back to idle", 32'({busy, nxt_valid}), 0);
        end

        // R9 partial words and floor at zero
        start(1'b0, 32'h100, mk_ctrl(8, 0, 0), 32'h5000_0000, 32'h0);
        wr(3, 0);
        check("R9 partial left", 32'(bytes_left), 5);
        wr(4, 0);
        check("R9 left 1", 32'(bytes_left), 1);
        check("R10 not done early", 32'(buf_done), 0);
        wr(4, 0);
        check("R9 floor zero", 32'(bytes_left), 0);
        check("R10 done on empty", 32'(buf_done), 1);
        check("R10 to link", 32'(buf_id), 3);
        @(negedge clk);

        // R10 frame end inside buffer 1 skips a usable buffer 2
        start(1'b1, 32'h200, mk_ctrl(16, 8, 0), 32'h6000_0002, 32'h7000_0000);
        wr(2, 1);
        check("R10 frame end done", 32'(buf_done), 1);
        check("R10 frame end to link", 32'(buf_id), 3);
        @(negedge clk);

        // R11 go ignored while busy
        start(1'b0, 32'h300, mk_ctrl(12, 0, 0), 32'h8000_0000, 32'h0);
        wr(4, 0);
        start(1'b1, 32'h900, mk_ctrl(4, 0, 1), 32'h9000_0003, 32'hA000_0000);
        check("R11 busy go ignored addr", wr_addr, 32'h8000_0004);
        check("R11 busy go ignored id", 32'(buf_id), 1);
        check("R11 busy go ignored left", 32'(bytes_left), 8);
        wr(4, 0); wr(4, 0);
        check("R11 link after ignore", nxt_addr, 32'h320);
        @(negedge clk);

        // R7 size errors
        start(1'b0, 32'h400, mk_ctrl(6, 0, 0), 32'hB000_0000, 32'h0);
        check("R7 size1 cfg_err", 32'({cfg_err, busy}), 32'h2);
        @(negedge clk);
        check("R7 cfg_err one cycle", 32'(cfg_err), 0);
        start(1'b0, 32'h400, mk_ctrl(4, 10, 0), 32'hB000_0000, 32'h0);
        check("R7 size2 ring cfg_err", 32'({cfg_err, busy}), 32'h2);
        start(1'b0, 32'h400, mk_ctrl(4, 10, 1), 32'hB000_0000, 32'hC000_0000);
        check("R7 size2 ignored chained", 32'({cfg_err, busy}), 32'h1);
        wr(4, 0);
        @(negedge clk);

        // R6 misaligned chain pointer
        start(1'b0, 32'h500, mk_ctrl(4, 0, 1), 32'hD000_0000, 32'hE000_0002);
        check("R6 ptr_err", 32'({ptr_err, busy}), 32'h2);
        start(1'b0, 32'h500, mk_ctrl(0, 4, 0), 32'hD000_0000, 32'hE000_0002);
        check("R6 ring pointer unrestricted", 32'({ptr_err, buf_id}), 32'h2);
        check("R8 continuation ignores low bits", wr_addr, 32'hE000_0000);
        wr(4, 0);
        @(negedge clk);

        finish_sim();
    end
endmodule